// File: doc/BRIEF.md
# Reset-Time Strap Sampler

The block watches the chip-enable line and, once it has stayed high for a fixed number of clock cycles, takes one snapshot of four strap inputs. It keeps that snapshot for as long as chip enable stays high, whatever the pins do afterwards. The pins are free to act as ordinary I/O once the snapshot is taken.

Three results are decoded from the held snapshot and two static configuration fields. The first is the boot mode: serial-flash boot, download boot, or an error code. The second is a boot-message print enable, which a 2-bit field can force on, force off, tie to strap B, or tie to the inverse of strap B. The third is the debug-port source, which a 1-bit field either fixes to the USB path or hands over to strap D.

A one-cycle pulse marks the moment of capture. If chip enable falls, the snapshot is cleared and sampling starts again on the next rise.

Top module: `strap_sampler`

## Requirements
- R1: While rst_ni is low, every output is 0: straps_o, boot_mode_o (0 means not yet sampled), print_en_o, dbg_pins_o, invalid_o and sample_done_o.
- R2: The straps are captured on the HOLD_CYCLES-th consecutive rising clock edge at which chip_en_i is high. After that edge, sample_done_o is high for exactly one cycle. After HOLD_CYCLES-1 such edges, nothing has been captured yet.
- R3: If chip_en_i is low at any edge before capture, the hold count restarts from zero and no capture occurs.
- R4: Once captured, straps_o = {d,c,b,a} stays unchanged while chip_en_i stays high, even if the strap pins change.
- R5: boot_mode_o after capture takes one of three values. It is 1 (serial-flash boot) when strap A is high and strap C is high; strap B is then a don't-care. It is 2 (download boot) when strap A is high, strap C is low and strap B is high. It is 3 (error) in every other case.
- R6: invalid_o is high after capture exactly when strap B and strap C were both low.
- R7: print_en_o after capture depends on print_ctrl_i. It is 1 for value 0, the inverse of strap B for value 1, strap B for value 2, and 0 for value 3.
- R8: dbg_pins_o after capture is 1 (debug from chip pins) only when dbg_sel_i is 1 and strap D was low. Otherwise it is 0 (USB debug path).
- R9: When chip_en_i is low at a clock edge after capture, all outputs return to 0 on that edge. The next high period samples afresh.
- R10: Before capture, boot_mode_o, print_en_o, dbg_pins_o and invalid_o are 0 regardless of the pins and fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chip_en_i | input | 1 | Chip enable; a rise starts the hold count |
| strap_a_i | input | 1 | Strap A, must be high for a valid boot |
| strap_b_i | input | 1 | Strap B, boot and print selection |
| strap_c_i | input | 1 | Strap C, boot selection |
| strap_d_i | input | 1 | Strap D, debug source selection |
| print_ctrl_i | input | 2 | Print-control configuration field |
| dbg_sel_i | input | 1 | Debug-source configuration field |
| straps_o | output | 4 | Captured straps {d,c,b,a} |
| boot_mode_o | output | 2 | 0 none, 1 serial-flash, 2 download, 3 error |
| print_en_o | output | 1 | Boot-message print enable |
| dbg_pins_o | output | 1 | 1 selects chip pins for debug, 0 selects USB |
| invalid_o | output | 1 | Strap B and C both low |
| sample_done_o | output | 1 | One-cycle pulse after capture |

## Verification
The capture, the snapshot outputs and sample_done_o all come from registers written on the HOLD_CYCLES-th high edge. The bench therefore counts edges from the rise of chip enable. It checks at the falling edge after edge HOLD_CYCLES-1 that nothing has been captured, and at the falling edge after edge HOLD_CYCLES that the capture has happened. The print and debug outputs are combinational on the held straps and the live fields. They are checked one time step after a field changes, with no clock edge in between. Clearing is due on the first edge at which chip enable is low, and the bench samples at the falling edge that follows.

// File: rtl/strap_pkg.sv
package strap_pkg;
  typedef enum logic [1:0] {
    BOOT_NONE = 2'd0,
    BOOT_SPI  = 2'd1,
    BOOT_DL   = 2'd2,
    BOOT_BAD  = 2'd3
  } boot_mode_e;

  typedef struct packed {
    logic d;
    logic c;
    logic b;
    logic a;
  } strap_t;

  localparam int unsigned StrapW = $bits(strap_t);
endpackage

// File: rtl/strap_hold_timer.sv
module strap_hold_timer #(
  parameter int unsigned HOLD_CYCLES = 750_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chip_en_i,
  input  logic held_i,
  output logic fire_o
);
  localparam int unsigned CntW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CntW-1:0] LastCnt = CntW'(HOLD_CYCLES - 1);

  logic [CntW-1:0] cnt_q;

  assign fire_o = chip_en_i && !held_i && (cnt_q == LastCnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!chip_en_i || held_i || fire_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CntW'(1);
    end
  end
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   chip_en_i,
  input  logic   fire_i,
  input  strap_t pins_i,
  output strap_t straps_o,
  output logic   held_o,
  output logic   done_o
);
  strap_t straps_q;
  logic   held_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      straps_q <= '0;
      held_q   <= 1'b0;
      done_q   <= 1'b0;
    end else if (!chip_en_i) begin
      straps_q <= '0;
      held_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= fire_i;
      if (fire_i) begin
        straps_q <= pins_i;
        held_q   <= 1'b1;
      end
    end
  end

  assign straps_o = straps_q;
  assign held_o   = held_q;
  assign done_o   = done_q;
endmodule

// File: rtl/strap_decode.sv
module strap_decode
  import strap_pkg::*;
(
  input  logic       held_i,
  input  strap_t     straps_i,
  input  logic [1:0] print_ctrl_i,
  input  logic       dbg_sel_i,
  output boot_mode_e mode_o,
  output logic       print_en_o,
  output logic       dbg_pins_o,
  output logic       invalid_o
);
  logic bad_combo;

  assign bad_combo = !straps_i.b && !straps_i.c;

  always_comb begin
    mode_o     = BOOT_NONE;
    print_en_o = 1'b0;
    dbg_pins_o = 1'b0;
    invalid_o  = 1'b0;
    if (held_i) begin
      invalid_o = bad_combo;
      if (!straps_i.a || bad_combo) mode_o = BOOT_BAD;
      else if (straps_i.c)          mode_o = BOOT_SPI;
      else                          mode_o = BOOT_DL;
      unique case (print_ctrl_i)
        2'd0:    print_en_o = 1'b1;
        2'd1:    print_en_o = !straps_i.b;
        2'd2:    print_en_o = straps_i.b;
        default: print_en_o = 1'b0;
      endcase
      dbg_pins_o = dbg_sel_i && !straps_i.d;
    end
  end
endmodule

// File: rtl/strap_sampler.sv
module strap_sampler
  import strap_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 750_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       chip_en_i,
  input  logic       strap_a_i,
  input  logic       strap_b_i,
  input  logic       strap_c_i,
  input  logic       strap_d_i,
  input  logic [1:0] print_ctrl_i,
  input  logic       dbg_sel_i,
  output logic [3:0] straps_o,
  output logic [1:0] boot_mode_o,
  output logic       print_en_o,
  output logic       dbg_pins_o,
  output logic       invalid_o,
  output logic       sample_done_o
);
  strap_t     pins, straps;
  logic       fire, held;
  boot_mode_e mode;

  assign pins = '{d: strap_d_i, c: strap_c_i, b: strap_b_i, a: strap_a_i};

  strap_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .chip_en_i (chip_en_i),
    .held_i    (held),
    .fire_o    (fire)
  );

  strap_capture u_capture (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .chip_en_i (chip_en_i),
    .fire_i    (fire),
    .pins_i    (pins),
    .straps_o  (straps),
    .held_o    (held),
    .done_o    (sample_done_o)
  );

  strap_decode u_decode (
    .held_i       (held),
    .straps_i     (straps),
    .print_ctrl_i (print_ctrl_i),
    .dbg_sel_i    (dbg_sel_i),
    .mode_o       (mode),
    .print_en_o   (print_en_o),
    .dbg_pins_o   (dbg_pins_o),
    .invalid_o    (invalid_o)
  );

  assign straps_o    = straps;
  assign boot_mode_o = mode;
endmodule

// File: rtl/strap_sampler_chk.sv
module strap_sampler_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       chip_en_i,
  input logic [1:0] print_ctrl_i,
  input logic [3:0] straps_o,
  input logic [1:0] boot_mode_o,
  input logic       print_en_o,
  input logic       invalid_o,
  input logic       sample_done_o
);
  logic held;
  assign held = (boot_mode_o != 2'd0);

  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_done_o |=> !sample_done_o);

  assert_capture_flags_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held && !$past(held)) |-> sample_done_o);

  assert_done_means_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_done_o |-> held);

  assert_enable_low_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chip_en_i |=> (!held && straps_o == 4'd0));

  assert_straps_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held && chip_en_i) |=> $stable(straps_o));

  assert_invalid_is_error_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> (boot_mode_o == 2'd3));

  assert_print_forced_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (print_ctrl_i == 2'd3) |-> !print_en_o);

  assert_idle_outputs_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !held |-> (!print_en_o && !invalid_o));
endmodule

bind strap_sampler strap_sampler_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .chip_en_i     (chip_en_i),
  .print_ctrl_i  (print_ctrl_i),
  .straps_o      (straps_o),
  .boot_mode_o   (boot_mode_o),
  .print_en_o    (print_en_o),
  .invalid_o     (invalid_o),
  .sample_done_o (sample_done_o)
);

// File: tb/tb_strap_sampler.sv
`timescale 1ns/1ps
module tb_strap_sampler;
  localparam int unsigned HOLD = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       chip_en_i = 1'b0;
  logic       strap_a_i = 1'b0, strap_b_i = 1'b0, strap_c_i = 1'b0, strap_d_i = 1'b0;
  logic [1:0] print_ctrl_i = 2'd0;
  logic       dbg_sel_i = 1'b0;
  logic [3:0] straps_o;
  logic [1:0] boot_mode_o;
  logic       print_en_o, dbg_pins_o, invalid_o, sample_done_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  strap_sampler #(.HOLD_CYCLES(HOLD)) dut (
    .clk_i, .rst_ni, .chip_en_i, .strap_a_i, .strap_b_i, .strap_c_i, .strap_d_i,
    .print_ctrl_i, .dbg_sel_i, .straps_o, .boot_mode_o, .print_en_o, .dbg_pins_o,
    .invalid_o, .sample_done_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic set_pins(input logic [3:0] s);
    {strap_d_i, strap_c_i, strap_b_i, strap_a_i} = s;
  endtask

  function automatic int exp_mode(input logic [3:0] s);
    if (!s[0] || (!s[1] && !s[2])) return 3;
    if (s[2]) return 1;
    return 2;
  endfunction

  function automatic int exp_print(input logic [3:0] s, input logic [1:0] pc);
    case (pc)
      2'd0: return 1;
      2'd1: return int'(!s[1]);
      2'd2: return int'(s[1]);
      default: return 0;
    endcase
  endfunction

  task automatic power_cycle_and_capture(input logic [3:0] s);
    chip_en_i = 1'b0;
    step();
    set_pins(s);
    chip_en_i = 1'b1;
    repeat (HOLD - 1) step();
    chk(boot_mode_o == 2'd0 && !sample_done_o, "R2 early", boot_mode_o, 0);
    step();
    chk(sample_done_o == 1'b1, "R2 done", sample_done_o, 1);
    chk(straps_o == s, "R2 capture", straps_o, s);
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    set_pins(4'b1111);
    chip_en_i = 1'b1;
    #1;
    chk({straps_o, boot_mode_o, print_en_o, dbg_pins_o, invalid_o, sample_done_o} == '0,
        "R1 reset", boot_mode_o, 0);
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    chip_en_i = 1'b0;
    step();

    // R10: before capture nothing decodes, whatever pins and fields say
    for (int pc = 0; pc < 4; pc++) begin
      print_ctrl_i = 2'(pc);
      dbg_sel_i = 1'b1;
      set_pins(4'b0000);
      #1;
      chk(!print_en_o && !dbg_pins_o && !invalid_o && boot_mode_o == 2'd0, "R10 idle",
          print_en_o, 0);
    end

    // exhaustive sweep of straps, then of both fields on each capture
    for (int s = 0; s < 16; s++) begin
      power_cycle_and_capture(4'(s));
      chk(int'(boot_mode_o) == exp_mode(4'(s)), "R5 mode", boot_mode_o, exp_mode(4'(s)));
      chk(invalid_o == (!s[1] && !s[2]), "R6 invalid", invalid_o, int'(!s[1] && !s[2]));
      for (int pc = 0; pc < 4; pc++) begin
        for (int ds = 0; ds < 2; ds++) begin
          print_ctrl_i = 2'(pc);
          dbg_sel_i = 1'(ds);
          #1;
          chk(int'(print_en_o) == exp_print(4'(s), 2'(pc)), "R7 print", print_en_o,
              exp_print(4'(s), 2'(pc)));
          chk(dbg_pins_o == (ds == 1 && !s[3]), "R8 debug", dbg_pins_o,
              int'(ds == 1 && !s[3]));
        end
      end
      step();
      chk(!sample_done_o, "R2 pulse end", sample_done_o, 0);
      // R4: later pin activity does not reach the snapshot
      set_pins(~4'(s));
      step();
      step();
      chk(straps_o == 4'(s), "R4 hold", straps_o, s);
      chk(int'(boot_mode_o) == exp_mode(4'(s)), "R4 mode hold", boot_mode_o,
          exp_mode(4'(s)));
    end

    // R9: enable low after capture clears everything
    power_cycle_and_capture(4'b0111);
    chip_en_i = 1'b0;
    step();
    chk(straps_o == 0 && boot_mode_o == 0 && !sample_done_o, "R9 clear", boot_mode_o, 0);
    set_pins(4'b0011);
    chip_en_i = 1'b1;
    repeat (HOLD) step();
    chk(straps_o == 4'b0011, "R9 resample", straps_o, 3);
    chk(boot_mode_o == 2'd2, "R9 resample mode", boot_mode_o, 2);

    // R3: a dip before the hold ends restarts the count
    chip_en_i = 1'b0;
    step();
    set_pins(4'b0101);
    chip_en_i = 1'b1;
    repeat (HOLD - 1) step();
    chip_en_i = 1'b0;
    step();
    chk(boot_mode_o == 2'd0 && !sample_done_o, "R3 no capture", boot_mode_o, 0);
    chip_en_i = 1'b1;
    repeat (HOLD - 1) step();
    chk(boot_mode_o == 2'd0, "R3 restart early", boot_mode_o, 0);
    step();
    chk(sample_done_o && straps_o == 4'b0101, "R3 restart capture", straps_o, 5);

    // R1: asynchronous reset after capture
    rst_ni = 1'b0;
    #1;
    chk(straps_o == 0 && boot_mode_o == 0 && !print_en_o && !sample_done_o, "R1 async",
        boot_mode_o, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule